// File: doc/BRIEF.md
# Serial Lane Test Pattern Generator

This block replaces the encoded character stream of one 10-bit lane of a serial video transmitter with test data. It produces one 10-bit word per clock. A 3-bit select input chooses the source of that word: a constant zero, the normal encoded data passing through, a pseudo-random bit stream, or a user-programmed cyclic pattern. A separate 10-bit output carries a companion clock-lane pattern.

The pseudo-random source is a linear feedback shift register with four selectable polynomials of length 7, 11, 15 and 31. It can emit ten new bits, eight new bits, or a single new bit per cycle. The cyclic source steps through eight programmable 10-bit words and holds each word for 1 to 8 cycles. The clock-lane source holds a 40-bit pattern that is loaded in one go. It can then rotate by one 10-bit word per cycle, which suits a clock that runs at a quarter of the character rate.

The control fields are plain inputs. The register bus that holds them and the serialiser that consumes the words are outside this block.

Top module: `lane_bist_patgen`

## Requirements
- R1: While rst_n is low, data_o and clk_lane_o are zero.
- R2: With sel_i = 3'b000, data_o is zero one clock later. With sel_i = 3'b001, data_o equals the data_i sampled at the previous clock edge. Any sel_i value with more than one bit set also gives zero one clock later. The encodings 3'b010 (PRBS) and 3'b100 (shift pattern) pick the two generators.
- R3: prbs_mode_i selects the feedback polynomial: 0 = x^11+x^9+1, 1 = x^15+x^14+1, 2 = x^7+x^6+1, 3 = x^31+x^28+1. Each step computes new = s[L-1]^s[T-1] and shifts it in at bit 0. While prbs_en_i is low, the register is loaded with L ones.
- R4: With prbs_width_i = 3 the LFSR takes 10 steps per cycle, and word bit i is the i-th new bit. When prbs_en_i is first sampled high, the first word appears on data_o (sel_i = 3'b010) after the second clock edge.
- R5: With prbs_width_i = 1 the LFSR takes 8 steps per cycle. Bits 7:0 carry the new bits in order, and bits 9:8 are zero.
- R6: With prbs_width_i = 2 the LFSR takes one step per cycle, and the new bit is copied onto all 10 bits.
- R7: With prbs_width_i = 0 the PRBS word is zero and the LFSR state holds. A later switch to another width therefore continues from the held state.
- R8: Shift word k is shift_pat_i[10k+9:10k]. With repeat value R, the e-th enabled cycle emits word floor(e/(R+1)) mod 8, so the words wrap after word 7. That word appears on data_o (sel_i = 3'b100) two clock edges after the edge that samples it.
- R9: Dropping shift_en_i for one cycle restarts the shift sequence at word 0 with a fresh hold count.
- R10: With clkpat_load_i high, the 40-bit clock pattern loads from clkpat_i, and clk_lane_o shows bits 9:0 after that edge. Load wins over rotation.
- R11: With clkpat_shift_i high and no load, the pattern rotates right by 10 bits each clock, so clk_lane_o steps through bits 19:10, 29:20, 39:30 and back to 9:0. With neither control high, the pattern holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Output source select |
| data_i | input | 10 | Normal encoded character |
| prbs_en_i | input | 1 | PRBS generator enable |
| prbs_mode_i | input | 2 | PRBS polynomial select |
| prbs_width_i | input | 2 | PRBS bits per cycle |
| shift_en_i | input | 1 | Shift pattern generator enable |
| shift_rep_i | input | 3 | Cycles per shift word minus one |
| shift_pat_i | input | 80 | Eight 10-bit shift pattern words |
| clkpat_i | input | 40 | Clock-lane pattern value |
| clkpat_load_i | input | 1 | Load clock-lane pattern |
| clkpat_shift_i | input | 1 | Rotate clock-lane pattern |
| data_o | output | 10 | Lane output word |
| clk_lane_o | output | 10 | Clock-lane pattern word |

## Verification
The hardest case to reach from the ports is an LFSR that holds its state while enabled. The stimulus runs the generator enabled at idle width for several cycles and then switches to full width without dropping the enable. The bench then expects the first word computed from the fresh seed, which it can only see if nothing advanced during the idle period. Two further cases need precise timing. One is a mid-sequence restart of the shift pattern, made with a one-cycle enable gap after the index has moved past word 0. The other is a collision of load and rotate on the clock lane, produced by raising both controls in the same cycle.

// File: rtl/lane_bist_pkg.sv
package lane_bist_pkg;
  localparam int LFSR_W = 31;
  typedef logic [LFSR_W-1:0] lfsr_t;

  localparam logic [2:0] SEL_ZERO  = 3'b000;
  localparam logic [2:0] SEL_DATA  = 3'b001;
  localparam logic [2:0] SEL_PRBS  = 3'b010;
  localparam logic [2:0] SEL_SHIFT = 3'b100;

  localparam logic [1:0] POLY_11 = 2'd0;
  localparam logic [1:0] POLY_15 = 2'd1;
  localparam logic [1:0] POLY_7  = 2'd2;
  localparam logic [1:0] POLY_31 = 2'd3;

  localparam logic [1:0] PW_IDLE = 2'd0;
  localparam logic [1:0] PW_BYTE = 2'd1;
  localparam logic [1:0] PW_BIT  = 2'd2;
  localparam logic [1:0] PW_WORD = 2'd3;

  // feedback tap positions (bit L-1 and bit T-1) for each polynomial
  function automatic lfsr_t lfsr_taps(input logic [1:0] mode);
    case (mode)
      POLY_11: return 31'h0000_0500;
      POLY_15: return 31'h0000_6000;
      POLY_7:  return 31'h0000_0060;
      default: return 31'h4800_0000;
    endcase
  endfunction

  // all-ones seed, which is also the live-length mask
  function automatic lfsr_t lfsr_seed(input logic [1:0] mode);
    case (mode)
      POLY_11: return 31'h0000_07FF;
      POLY_15: return 31'h0000_7FFF;
      POLY_7:  return 31'h0000_007F;
      default: return 31'h7FFF_FFFF;
    endcase
  endfunction

  // one Fibonacci step: new bit enters at bit 0
  function automatic lfsr_t lfsr_next(input lfsr_t s, input logic [1:0] mode);
    logic fb;
    fb = ^(s & lfsr_taps(mode));
    return ((s << 1) | lfsr_t'(fb)) & lfsr_seed(mode);
  endfunction
endpackage

// File: rtl/lane_bist_prbs.sv
module lane_bist_prbs
  import lane_bist_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        width_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int BYTE_W = 8;

  lfsr_t             state_q, state_n;
  logic [WORD_W-1:0] word_q, word_n, bits;
  int                nsteps;

  always_comb begin
    case (width_i)
      PW_BYTE: nsteps = BYTE_W;
      PW_BIT:  nsteps = 1;
      PW_WORD: nsteps = WORD_W;
      default: nsteps = 0;
    endcase
  end

  // unrolled multi-step LFSR: up to WORD_W steps per cycle
  always_comb begin
    state_n = state_q;
    bits    = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < nsteps) begin
        state_n = lfsr_next(state_n, mode_i);
        bits[i] = state_n[0];
      end
    end
  end

  always_comb begin
    word_n = '0;
    case (width_i)
      PW_BYTE: word_n[BYTE_W-1:0] = bits[BYTE_W-1:0];
      PW_BIT:  word_n = {WORD_W{bits[0]}};
      PW_WORD: word_n = bits;
      default: word_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= lfsr_seed(POLY_11);
      word_q  <= '0;
    end else if (!en_i) begin
      state_q <= lfsr_seed(mode_i);
      word_q  <= '0;
    end else begin
      state_q <= state_n;
      word_q  <= word_n;
    end
  end

  assign word_o = word_q;

  // R3
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  // R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && width_i == PW_BYTE) |=> word_q[WORD_W-1:BYTE_W] == '0);
  // R6
  bit_replicated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && width_i == PW_BIT) |=> (word_q == '0 || word_q == '1));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && width_i == PW_IDLE) |=> (word_q == '0 && $stable(state_q)));
endmodule

// File: rtl/lane_bist_shift.sv
module lane_bist_shift #(
  parameter int WORD_W = 10,
  parameter int NWORDS = 8,
  parameter int REP_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [REP_W-1:0]         rep_i,
  input  logic [WORD_W*NWORDS-1:0] pat_i,
  output logic [WORD_W-1:0]        word_o
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic [WORD_W-1:0] words [NWORDS];
  logic [IDX_W-1:0]  idx_q;
  logic [REP_W-1:0]  hold_q;
  logic [WORD_W-1:0] word_q;
  logic              word_adv;

  for (genvar g = 0; g < NWORDS; g++) begin : g_slice
    assign words[g] = pat_i[g*WORD_W +: WORD_W];
  end

  // named event: current word has been held for rep_i+1 cycles
  assign word_adv = en_i && (hold_q >= rep_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      hold_q <= '0;
      word_q <= '0;
    end else if (!en_i) begin
      idx_q  <= '0;
      hold_q <= '0;
      word_q <= '0;
    end else begin
      word_q <= words[idx_q];
      if (word_adv) begin
        hold_q <= '0;
        idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign word_o = word_q;

  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !word_adv) |=> $stable(idx_q));
  // R8
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_adv && idx_q == LAST_IDX) |=> idx_q == '0);
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (idx_q == '0 && hold_q == '0 && word_q == '0));
endmodule

// File: rtl/lane_bist_clkpat.sv
module lane_bist_clkpat #(
  parameter int WORD_W    = 10,
  parameter int CLK_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        shift_i,
  input  logic [WORD_W*CLK_WORDS-1:0] pat_i,
  output logic [WORD_W-1:0]           word_o
);
  localparam int PAT_W = WORD_W * CLK_WORDS;

  logic [PAT_W-1:0] pat_q;
  logic             rotate;

  assign rotate = shift_i && !load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= '0;
    else if (load_i) pat_q <= pat_i;
    else if (rotate) pat_q <= {pat_q[WORD_W-1:0], pat_q[PAT_W-1:WORD_W]};
  end

  assign word_o = pat_q[WORD_W-1:0];

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> pat_q == $past(pat_i));
  // R11
  rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> $countones(pat_q) == $countones($past(pat_q)));
  // R11
  rotate_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> word_o == $past(pat_q[2*WORD_W-1:WORD_W]));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(pat_q));
endmodule

// File: rtl/lane_bist_patgen.sv
module lane_bist_patgen
  import lane_bist_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int NWORDS    = 8,
  parameter int REP_W     = 3,
  parameter int CLK_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  sel_i,
  input  logic [WORD_W-1:0]           data_i,
  input  logic                        prbs_en_i,
  input  logic [1:0]                  prbs_mode_i,
  input  logic [1:0]                  prbs_width_i,
  input  logic                        shift_en_i,
  input  logic [REP_W-1:0]            shift_rep_i,
  input  logic [WORD_W*NWORDS-1:0]    shift_pat_i,
  input  logic [WORD_W*CLK_WORDS-1:0] clkpat_i,
  input  logic                        clkpat_load_i,
  input  logic                        clkpat_shift_i,
  output logic [WORD_W-1:0]           data_o,
  output logic [WORD_W-1:0]           clk_lane_o
);
  logic [WORD_W-1:0] prbs_word, shift_word, mux_word, out_q;

  lane_bist_prbs #(.WORD_W(WORD_W)) u_prbs (
    .clk(clk), .rst_n(rst_n), .en_i(prbs_en_i), .mode_i(prbs_mode_i),
    .width_i(prbs_width_i), .word_o(prbs_word));

  lane_bist_shift #(.WORD_W(WORD_W), .NWORDS(NWORDS), .REP_W(REP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en_i(shift_en_i), .rep_i(shift_rep_i),
    .pat_i(shift_pat_i), .word_o(shift_word));

  lane_bist_clkpat #(.WORD_W(WORD_W), .CLK_WORDS(CLK_WORDS)) u_clkpat (
    .clk(clk), .rst_n(rst_n), .load_i(clkpat_load_i), .shift_i(clkpat_shift_i),
    .pat_i(clkpat_i), .word_o(clk_lane_o));

  always_comb begin
    case (sel_i)
      SEL_DATA:  mux_word = data_i;
      SEL_PRBS:  mux_word = prbs_word;
      SEL_SHIFT: mux_word = shift_word;
      default:   mux_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= mux_word;
  end

  assign data_o = out_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> (data_o == '0 && clk_lane_o == '0));
  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SEL_DATA) |=> data_o == $past(data_i));
  // R2
  bad_select_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$onehot0(sel_i) || sel_i == SEL_ZERO) |=> data_o == '0);
endmodule

// File: tb/lane_bist_patgen_tb.sv
`timescale 1ns/1ps
module lane_bist_patgen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel;
  logic [9:0]  din;
  logic        p_en, s_en, c_load, c_shift;
  logic [1:0]  p_mode, p_width;
  logic [2:0]  s_rep;
  logic [79:0] s_pat;
  logic [39:0] c_pat;
  logic [9:0]  dout, clane;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  lane_bist_patgen u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .data_i(din),
    .prbs_en_i(p_en), .prbs_mode_i(p_mode), .prbs_width_i(p_width),
    .shift_en_i(s_en), .shift_rep_i(s_rep), .shift_pat_i(s_pat),
    .clkpat_i(c_pat), .clkpat_load_i(c_load), .clkpat_shift_i(c_shift),
    .data_o(dout), .clk_lane_o(clane));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent PRBS reference
  logic [30:0] ms;
  int mL, mT;

  task automatic model_seed(input logic [1:0] mode);
    logic [31:0] m32;
    case (mode)
      2'd0: begin mL = 11; mT = 9;  end
      2'd1: begin mL = 15; mT = 14; end
      2'd2: begin mL = 7;  mT = 6;  end
      default: begin mL = 31; mT = 28; end
    endcase
    m32 = (32'h1 << mL) - 32'h1;
    ms  = m32[30:0];
  endtask

  function automatic logic model_bit();
    logic [30:0] a, b, mk;
    logic [31:0] m32;
    logic fb;
    a   = ms >> (mL - 1);
    b   = ms >> (mT - 1);
    fb  = a[0] ^ b[0];
    m32 = (32'h1 << mL) - 32'h1;
    mk  = m32[30:0];
    ms  = ((ms << 1) | {30'b0, fb}) & mk;
    return fb;
  endfunction

  function automatic logic [9:0] model_word(input logic [1:0] width);
    logic [9:0] w;
    logic bt;
    w = '0;
    case (width)
      2'd3: for (int i = 0; i < 10; i++) w[i] = model_bit();
      2'd1: for (int i = 0; i < 8; i++) w[i] = model_bit();
      2'd2: begin bt = model_bit(); w = {10{bt}}; end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [9:0] sword(input int k);
    return s_pat[10*k +: 10];
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; sel = 3'b001; din = 10'h3FF; c_load = 1'b1; c_pat = 40'hFF_FFFF_FFFF;
    p_en = 0; s_en = 0; c_shift = 0; p_mode = 0; p_width = 0; s_rep = 0; s_pat = '0;
    step(); step();
    chk("R1 data_o in reset", dout, 10'h000);
    chk("R1 clk_lane_o in reset", clane, 10'h000);
    sel = 3'b000; din = '0; c_load = 1'b0; c_pat = '0;
    rst_n = 1'b1;
    step();
    chk("R1 data_o after release", dout, 10'h000);
  endtask

  task automatic t_select();
    logic [9:0] vals [4] = '{10'h155, 10'h2AA, 10'h001, 10'h3C7};
    sel = 3'b001;
    foreach (vals[i]) begin
      din = vals[i];
      step();
      chk("R2 pass-through", dout, vals[i]);
    end
    din = 10'h3FF; sel = 3'b000; step();
    chk("R2 select 000 zero", dout, 10'h000);
    // generators running so an invalid code cannot hide behind zero
    p_en = 1; p_width = 2'd3; s_en = 1; s_pat = {8{10'h3FF}};
    step();
    for (int c = 3; c < 8; c++) begin
      if (c == 4) continue;
      sel = 3'(c);
      step();
      chk("R2 invalid select zero", dout, 10'h000);
    end
    p_en = 0; s_en = 0; step();
  endtask

  task automatic t_prbs(input logic [1:0] mode, input logic [1:0] width, input int n,
                        input string req);
    sel = 3'b010; p_en = 0; p_mode = mode; p_width = width;
    step();
    model_seed(mode);
    p_en = 1;
    step(); step();
    for (int k = 0; k < n; k++) begin
      chk(req, dout, model_word(width));
      step();
    end
    p_en = 0; step();
  endtask

  task automatic t_prbs_idle_hold();
    sel = 3'b010; p_en = 0; p_mode = 2'd2; p_width = 2'd0;
    step();
    model_seed(2'd2);
    p_en = 1;
    step(); step();
    for (int k = 0; k < 5; k++) begin
      chk("R7 idle width zero", dout, 10'h000);
      step();
    end
    p_width = 2'd3;
    step(); step();
    chk("R7 state held through idle", dout, model_word(2'd3));
    step();
    chk("R7 continues after idle", dout, model_word(2'd3));
    p_en = 0; step();
  endtask

  task automatic t_shift(input logic [2:0] rep);
    int n;
    sel = 3'b100; s_en = 0; s_rep = rep;
    step();
    s_en = 1;
    step(); step();
    n = 8 * (int'(rep) + 1) + 6;
    for (int e = 0; e < n; e++) begin
      chk("R8 shift word order and hold", dout, sword((e / (int'(rep) + 1)) % 8));
      step();
    end
    s_en = 0; step();
  endtask

  task automatic t_shift_restart();
    sel = 3'b100; s_rep = 3'd1; s_en = 0;
    step();
    s_en = 1;
    step(); step();
    chk("R9 pre-restart word 0", dout, sword(0));
    step(); step();
    chk("R9 pre-restart word 1", dout, sword(1));
    s_en = 0; step();
    s_en = 1; step();
    chk("R9 gap gives zero", dout, 10'h000);
    step();
    chk("R9 restart at word 0", dout, sword(0));
    step();
    chk("R9 fresh hold count", dout, sword(0));
    step();
    chk("R9 then word 1", dout, sword(1));
    s_en = 0; step();
  endtask

  task automatic t_clk_lane();
    logic [39:0] p1, p2;
    p1 = {10'h2C1, 10'h1B2, 10'h0A3, 10'h394};
    p2 = {10'h011, 10'h022, 10'h033, 10'h044};
    c_pat = p1; c_load = 1; c_shift = 0;
    step();
    chk("R10 load shows low word", clane, p1[9:0]);
    c_load = 0; c_pat = p2;
    step(); step();
    chk("R11 hold without controls", clane, p1[9:0]);
    c_shift = 1;
    for (int j = 1; j <= 6; j++) begin
      step();
      chk("R11 rotation", clane, p1[10*(j%4) +: 10]);
    end
    c_load = 1;
    step();
    chk("R10 load wins over rotate", clane, p2[9:0]);
    c_load = 0; c_shift = 0;
    step();
    chk("R11 hold after load", clane, p2[9:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) s_pat = '0;
    t_reset();
    t_select();
    t_prbs(2'd0, 2'd3, 12, "R3 R4 PRBS11 10-bit");
    t_prbs(2'd1, 2'd3, 12, "R3 R4 PRBS15 10-bit");
    t_prbs(2'd2, 2'd3, 20, "R3 R4 PRBS7 10-bit");
    t_prbs(2'd3, 2'd3, 12, "R3 R4 PRBS31 10-bit");
    t_prbs(2'd0, 2'd1, 10, "R5 PRBS11 8-bit");
    t_prbs(2'd3, 2'd1, 10, "R5 PRBS31 8-bit");
    t_prbs(2'd2, 2'd2, 30, "R6 PRBS7 1-bit");
    t_prbs(2'd1, 2'd2, 20, "R6 PRBS15 1-bit");
    t_prbs_idle_hold();
    for (int k = 0; k < 8; k++) s_pat[10*k +: 10] = 10'((k * 97 + 13) % 1024);
    t_shift(3'd0);
    t_shift(3'd2);
    t_shift(3'd7);
    t_shift_restart();
    t_clk_lane();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule